// File: doc/BRIEF.md
# Serial Port Register Front End with Triggered Receive Queue

This block is the register side of a serial port. A processor reaches it through a simple byte-wide register port. The line side hands it received bytes over a valid/ready stream and takes transmit bytes as a single-cycle strobe. Received bytes go into a small circular queue. A programmable fill threshold decides when the receive-full flag and the receive interrupt come on.

Status flags are cleared by writing zero to them; writing one leaves a flag as it is. The two transmit flags re-arm after a status read while the transmitter is enabled. The transmit interrupt follows one control bit directly. The bit-level shifter, baud generation and line error detection sit outside; only a break strobe comes in.

Top module: `uart_rxq_regs`

## Requirements
- R1: After reset these registers read as follows: control (0x08) 0x20, bit-rate (0x04) 0xff, status (0x10) 0x60, mode (0x00) 0x00, queue control (0x18) 0x00, count (0x1c) 0, port (0x20) 0x00. After reset `irq_rx`, `irq_tx`, `tx_valid` and `rx_ready` are all 0.
- R2: Writes are masked as follows: mode with 0x7b, control with 0xfa, port with 0xf3. Writes to bit-rate and queue control are stored in full.
- R3: The receive queue holds 16 bytes and returns them oldest first. A byte accepted while 16 are held is dropped. The held count reads at 0x1c.
- R4: `rx_ready` equals control bit 4. When it is 0, no byte is taken in.
- R5: Queue control bits 7:6 select the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14.
- R6: When a push leaves the count at or above the threshold, status bit 1 (receive full) is set. If control bit 6 is also 1, `irq_rx` is asserted from the next cycle.
- R7: Reading 0x14 returns the oldest byte and removes it. Status bit 1 clears if the count then falls below the threshold. A read of 0x14 while the queue is empty returns 0 and changes nothing.
- R8: Writing queue control with bit 1 set empties the queue, zeroes the count and clears status bit 1.
- R9: Status bits are 6 transmit end, 5 transmit empty, 4 break, 1 receive full and 0 data ready. Writing 0 to a bit clears it. Writing 0 to bit 1 or bit 0 deasserts `irq_rx`. A control write with bit 6 at 0 also deasserts `irq_rx`.
- R10: A status read while control bit 5 is 1 sets transmit end and transmit empty afterwards. A control write with bit 5 at 0 sets transmit end.
- R11: A write to 0x0c puts that byte on `tx_data` with `tx_valid` high for exactly the next cycle, and clears transmit empty.
- R12: `irq_tx` equals control bit 7, from the cycle after the control write.
- R13: A `brk_pulse` sets status bit 4.
- R14: A push and a pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Byte acceptance enabled |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| brk_pulse | input | 1 | Break detected strobe |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The bench uses the default configuration: a 16-entry queue, 8-bit data and the four thresholds 1, 4, 8 and 14. With this small depth it can sweep every threshold setting through every fill level from empty to full, push past full, and drain back to empty. At each step it checks count, receive-full and interrupt against arithmetic on the count and the threshold. The depth also makes the wrap of both pointers and the overflow drop cheap to reach, along with same-cycle push and pop.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
   localparam int OFF_MODE   = 'h00;
   localparam int OFF_RATE   = 'h04;
   localparam int OFF_CTRL   = 'h08;
   localparam int OFF_TXD    = 'h0c;
   localparam int OFF_STAT   = 'h10;
   localparam int OFF_RXD    = 'h14;
   localparam int OFF_QCTL   = 'h18;
   localparam int OFF_COUNT  = 'h1c;
   localparam int OFF_PORT   = 'h20;

   localparam logic [7:0] MASK_MODE = 8'h7b;
   localparam logic [7:0] MASK_CTRL = 8'hfa;
   localparam logic [7:0] MASK_PORT = 8'hf3;

   localparam logic [7:0] RST_CTRL = 8'h20;
   localparam logic [7:0] RST_RATE = 8'hff;

   // control bit positions
   localparam int CB_TXIE  = 7;
   localparam int CB_RXIE  = 6;
   localparam int CB_TXEN  = 5;
   localparam int CB_RXEN  = 4;
   // status bit positions
   localparam int SB_TEND  = 6;
   localparam int SB_TEMP  = 5;
   localparam int SB_BRK   = 4;
   localparam int SB_RFULL = 1;
   localparam int SB_DRDY  = 0;
   // queue control
   localparam int QB_FLUSH = 1;
endpackage

// File: rtl/uart_rxq_trig.sv
module uart_rxq_trig #(
   parameter int CNT_W = 5,
   parameter int DEPTH = 16,
   parameter int LVL0  = 1,
   parameter int LVL1  = 4,
   parameter int LVL2  = 8,
   parameter int LVL3  = 14
) (
   input  logic [1:0]       sel,
   output logic [CNT_W-1:0] level
);
   initial begin
      if (LVL0 < 1 || LVL1 < 1 || LVL2 < 1 || LVL3 < 1)
         $error("threshold levels must be at least 1");
      if (LVL0 > DEPTH || LVL1 > DEPTH || LVL2 > DEPTH || LVL3 > DEPTH)
         $error("threshold levels must not exceed DEPTH");
   end

   always_comb begin
      unique case (sel)
         2'd0:    level = CNT_W'(LVL0);
         2'd1:    level = CNT_W'(LVL1);
         2'd2:    level = CNT_W'(LVL2);
         default: level = CNT_W'(LVL3);
      endcase
   end
endmodule

// File: rtl/uart_rxq_fifo.sv
module uart_rxq_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              flush,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  count_nxt,
   output logic              full,
   output logic              empty
);
   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_inc, rd_inc;

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign head  = empty ? '0 : mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_inc = wr_ptr + PTR_W'(1);
         assign rd_inc = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_comb begin
      if (flush) count_nxt = '0;
      else       count_nxt = count + CNT_W'(push) - CNT_W'(pop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         count <= count_nxt;
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (push) wr_ptr <= wr_inc;
            if (pop)  rd_ptr <= rd_inc;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/uart_rxq_regs.sv
module uart_rxq_regs #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 16,
   parameter int LVL0   = 1,
   parameter int LVL1   = 4,
   parameter int LVL2   = 8,
   parameter int LVL3   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              brk_pulse,
   output logic              irq_rx,
   output logic              irq_tx
);
   import uart_rxq_pkg::*;

   localparam int CNT_W = $clog2(DEPTH + 1);

   initial begin
      if (DATA_W != 8) $error("register layout assumes DATA_W == 8");
      if (ADDR_W < 6)  $error("ADDR_W must reach offset 0x20");
      if (DEPTH < 2)   $error("DEPTH must be at least 2");
      if (CNT_W > DATA_W) $error("count must fit in one data byte");
   end

   // register state
   logic [DATA_W-1:0] r_mode, r_rate, r_ctrl, r_qctl, r_port;
   logic f_tend, f_temp, f_brk, f_rfull, f_drdy;
   logic irq_rx_q;
   logic tx_valid_q;
   logic [DATA_W-1:0] tx_data_q;

   // decode
   logic wr, rd;
   assign wr = bus_sel &&  bus_we;
   assign rd = bus_sel && !bus_we;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
      return a == ADDR_W'(off);
   endfunction

   logic wr_ctrl, wr_txd, wr_stat, wr_qctl;
   logic rd_stat, rd_rxd;
   assign wr_ctrl = wr && hit(bus_addr, OFF_CTRL);
   assign wr_txd  = wr && hit(bus_addr, OFF_TXD);
   assign wr_stat = wr && hit(bus_addr, OFF_STAT);
   assign wr_qctl = wr && hit(bus_addr, OFF_QCTL);
   assign rd_stat = rd && hit(bus_addr, OFF_STAT);
   assign rd_rxd  = rd && hit(bus_addr, OFF_RXD);

   // queue
   logic [DATA_W-1:0] q_head;
   logic [CNT_W-1:0]  q_cnt, q_cnt_nxt, trig_lvl;
   logic q_full, q_empty;
   logic flush_req, push_ok, pop_ok;

   assign rx_ready  = r_ctrl[CB_RXEN];
   assign flush_req = wr_qctl && bus_wdata[QB_FLUSH];
   assign push_ok   = rx_valid && rx_ready && !q_full && !flush_req;
   assign pop_ok    = rd_rxd && !q_empty;

   uart_rxq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_ok),
      .pop       (pop_ok),
      .flush     (flush_req),
      .wdata     (rx_data),
      .head      (q_head),
      .count     (q_cnt),
      .count_nxt (q_cnt_nxt),
      .full      (q_full),
      .empty     (q_empty)
   );

   uart_rxq_trig #(
      .CNT_W(CNT_W), .DEPTH(DEPTH),
      .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
   ) u_trig (
      .sel   (r_qctl[7:6]),
      .level (trig_lvl)
   );

   logic reach_trig;
   assign reach_trig = push_ok && (q_cnt_nxt >= trig_lvl);

   // plain registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_mode <= '0;
         r_rate <= RST_RATE;
         r_ctrl <= RST_CTRL;
         r_qctl <= '0;
         r_port <= '0;
      end else if (wr) begin
         if (hit(bus_addr, OFF_MODE)) r_mode <= bus_wdata & MASK_MODE;
         if (hit(bus_addr, OFF_RATE)) r_rate <= bus_wdata;
         if (wr_ctrl)                 r_ctrl <= bus_wdata & MASK_CTRL;
         if (wr_qctl)                 r_qctl <= bus_wdata;
         if (hit(bus_addr, OFF_PORT)) r_port <= bus_wdata & MASK_PORT;
      end
   end

   // status flags: clear by writing zero, later events take priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_tend   <= 1'b1;
         f_temp   <= 1'b1;
         f_brk    <= 1'b0;
         f_rfull  <= 1'b0;
         f_drdy   <= 1'b0;
         irq_rx_q <= 1'b0;
      end else begin
         if (wr_ctrl && !bus_wdata[CB_TXEN]) f_tend <= 1'b1;
         if (wr_stat && !bus_wdata[SB_TEND]) f_tend <= 1'b0;
         if (rd_stat && r_ctrl[CB_TXEN])     f_tend <= 1'b1;

         if (wr_txd)                         f_temp <= 1'b0;
         if (wr_stat && !bus_wdata[SB_TEMP]) f_temp <= 1'b0;
         if (rd_stat && r_ctrl[CB_TXEN])     f_temp <= 1'b1;

         if (wr_stat && !bus_wdata[SB_BRK])  f_brk <= 1'b0;
         if (brk_pulse)                      f_brk <= 1'b1;

         if (wr_stat && !bus_wdata[SB_DRDY]) f_drdy <= 1'b0;

         if (wr_stat && !bus_wdata[SB_RFULL])       f_rfull <= 1'b0;
         if (pop_ok && (q_cnt_nxt < trig_lvl))      f_rfull <= 1'b0;
         if (reach_trig)                            f_rfull <= 1'b1;
         if (flush_req)                             f_rfull <= 1'b0;

         if (wr_ctrl && !bus_wdata[CB_RXIE]) irq_rx_q <= 1'b0;
         if (wr_stat && (!bus_wdata[SB_RFULL] || !bus_wdata[SB_DRDY]))
            irq_rx_q <= 1'b0;
         if (reach_trig && r_ctrl[CB_RXIE])  irq_rx_q <= 1'b1;
      end
   end

   // transmit strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid_q <= 1'b0;
         tx_data_q  <= '0;
      end else begin
         tx_valid_q <= wr_txd;
         if (wr_txd) tx_data_q <= bus_wdata;
      end
   end

   assign tx_valid = tx_valid_q;
   assign tx_data  = tx_data_q;
   assign irq_rx   = irq_rx_q;
   assign irq_tx   = r_ctrl[CB_TXIE];

   // read mux
   logic [DATA_W-1:0] stat_word;
   always_comb begin
      stat_word = '0;
      stat_word[SB_TEND]  = f_tend;
      stat_word[SB_TEMP]  = f_temp;
      stat_word[SB_BRK]   = f_brk;
      stat_word[SB_RFULL] = f_rfull;
      stat_word[SB_DRDY]  = f_drdy;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         if      (hit(bus_addr, OFF_MODE))  bus_rdata = r_mode;
         else if (hit(bus_addr, OFF_RATE))  bus_rdata = r_rate;
         else if (hit(bus_addr, OFF_CTRL))  bus_rdata = r_ctrl;
         else if (hit(bus_addr, OFF_STAT))  bus_rdata = stat_word;
         else if (hit(bus_addr, OFF_RXD))   bus_rdata = q_head;
         else if (hit(bus_addr, OFF_QCTL))  bus_rdata = r_qctl;
         else if (hit(bus_addr, OFF_COUNT)) bus_rdata = DATA_W'(q_cnt);
         else if (hit(bus_addr, OFF_PORT))  bus_rdata = r_port;
      end
   end
endmodule

// File: rtl/uart_rxq_check.sv
module uart_rxq_check #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic [DATA_W-1:0] tx_data,
   input logic              irq_tx,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  trig,
   input logic              push,
   input logic              pop,
   input logic              flush,
   input logic              rfull
);
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready && cnt == CNT_W'(DEPTH) && !pop && !flush)
      |=> cnt == CNT_W'(DEPTH));

   a_r6_rfull_set: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && (32'(cnt) + 1 >= 32'(trig))) |=> rfull);

   a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == ADDR_W'('h14) && cnt == '0
       && !(rx_valid && rx_ready)) |=> cnt == '0);

   a_r11_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == ADDR_W'('h0c))
      |=> (tx_valid && tx_data == $past(bus_wdata)));

   a_r12_irq_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && bus_addr == ADDR_W'('h08))
      |=> irq_tx == $past(bus_wdata[7]));

   a_r14_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(cnt));
endmodule

bind uart_rxq_regs uart_rxq_check #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
) u_check (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .tx_valid  (tx_valid),
   .tx_data   (tx_data),
   .irq_tx    (irq_tx),
   .cnt       (q_cnt),
   .trig      (trig_lvl),
   .push      (push_ok),
   .pop       (pop_ok),
   .flush     (flush_req),
   .rfull     (f_rfull)
);

// File: tb/uart_rxq_regs_bench.sv
module uart_rxq_regs_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 0, bus_we = 0;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic rx_valid = 0;
   logic [7:0] rx_data = '0;
   logic rx_ready, tx_valid, irq_rx, irq_tx;
   logic [7:0] tx_data;
   logic brk_pulse = 0;

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rxq_regs u_uart_rxq_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .brk_pulse(brk_pulse),
      .irq_rx(irq_rx), .irq_tx(irq_tx)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = 6'(a); bus_wdata = 8'(d);
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      bus_sel = 1; bus_we = 0; bus_addr = 6'(a);
      #1 d = int'(bus_rdata);
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic push(input int d);
      @(negedge clk);
      rx_valid = 1; rx_data = 8'(d);
      @(negedge clk);
      rx_valid = 0;
   endtask

   task automatic chk_reg(input string req, input int a, input int exp);
      int v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   function automatic int lvl(input int s);
      case (s)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset values
      chk("R1 rx_ready", int'(rx_ready), 0);
      chk("R1 irq_rx", int'(irq_rx), 0);
      chk("R1 irq_tx", int'(irq_tx), 0);
      chk("R1 tx_valid", int'(tx_valid), 0);
      chk_reg("R1 ctrl", 'h08, 'h20);
      chk_reg("R1 rate", 'h04, 'hff);
      chk_reg("R1 status", 'h10, 'h60);
      chk_reg("R1 mode", 'h00, 'h00);
      chk_reg("R1 qctl", 'h18, 'h00);
      chk_reg("R1 count", 'h1c, 0);
      chk_reg("R1 port", 'h20, 'h00);

      // R2 write masks
      wr('h00, 'hff); chk_reg("R2 mode mask", 'h00, 'h7b);
      wr('h20, 'hff); chk_reg("R2 port mask", 'h20, 'hf3);
      wr('h04, 'h5a); chk_reg("R2 rate full", 'h04, 'h5a);
      wr('h18, 'hc5); chk_reg("R2 qctl full", 'h18, 'hc5);
      wr('h08, 'hff); chk_reg("R2 ctrl mask", 'h08, 'hfa);

      // R12 transmit interrupt
      chk("R12 irq_tx high", int'(irq_tx), 1);
      wr('h08, 'h20);
      chk("R12 irq_tx low", int'(irq_tx), 0);

      // R11 transmit strobe
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = 6'h0c; bus_wdata = 8'h3c;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
      chk("R11 tx_valid", int'(tx_valid), 1);
      chk("R11 tx_data", int'(tx_data), 'h3c);
      @(negedge clk);
      chk("R11 tx_valid one cycle", int'(tx_valid), 0);
      wr('h08, 'h00);
      chk_reg("R11 temp cleared", 'h10, 'h40);

      // R10 re-arm and control write
      wr('h10, 'h00);
      chk_reg("R9 all cleared", 'h10, 'h00);
      wr('h08, 'h00);
      chk_reg("R10 ctrl write sets tend", 'h10, 'h40);
      wr('h10, 'h00);
      wr('h08, 'h20);
      wr('h10, 'h00);
      rd('h10, v);
      chk("R10 read returns before re-arm", v, 'h00);
      chk_reg("R10 re-armed", 'h10, 'h60);

      // R13 break
      @(negedge clk); brk_pulse = 1;
      @(negedge clk); brk_pulse = 0;
      chk_reg("R13 break set", 'h10, 'h70);
      wr('h10, 'hef);
      wr('h08, 'h00);
      chk_reg("R9 break cleared", 'h10, 'h60);

      // R4 acceptance gate
      chk("R4 rx_ready off", int'(rx_ready), 0);
      push('h11);
      chk_reg("R4 no byte taken", 'h1c, 0);
      wr('h08, 'h50);
      chk("R4 rx_ready on", int'(rx_ready), 1);

      // R3 R5 R6 R7 R8 sweep over all thresholds and fill levels
      for (int s = 0; s < 4; s++) begin
         wr('h18, (s << 6) | 2);
         chk_reg("R8 flushed count", 'h1c, 0);
         wr('h10, 'hfc);
         chk("R9 irq_rx cleared", int'(irq_rx), 0);
         for (int k = 1; k <= 16; k++) begin
            push(s * 32 + k);
            chk_reg("R3 count after push", 'h1c, k);
            rd('h10, v);
            chk("R6 rfull after push", (v >> 1) & 1, (k >= lvl(s)) ? 1 : 0);
            chk("R6 irq_rx after push", int'(irq_rx), (k >= lvl(s)) ? 1 : 0);
         end
         push('hee);
         push('hef);
         chk_reg("R3 overflow dropped", 'h1c, 16);
         for (int k = 1; k <= 16; k++) begin
            rd('h14, v);
            chk("R7 fifo order", v, s * 32 + k);
            chk_reg("R7 count after pop", 'h1c, 16 - k);
            rd('h10, v);
            chk("R7 rfull after pop", (v >> 1) & 1, ((16 - k) >= lvl(s)) ? 1 : 0);
         end
         // R8 flush clears rfull with a partly filled queue
         for (int k = 0; k < lvl(s); k++) push(k);
         rd('h10, v);
         chk("R8 rfull before flush", (v >> 1) & 1, 1);
         wr('h18, (s << 6) | 2);
         rd('h10, v);
         chk("R8 rfull after flush", (v >> 1) & 1, 0);
         chk_reg("R8 count after flush", 'h1c, 0);
      end

      // R7 empty read
      chk_reg("R7 empty read data", 'h14, 0);
      chk_reg("R7 empty read count", 'h1c, 0);

      // R9 interrupt clearing paths
      wr('h18, 'h00);
      wr('h10, 'hfc);
      push('h21);
      chk("R6 irq on trigger 1", int'(irq_rx), 1);
      wr('h08, 'h10);
      chk("R9 ctrl bit6 clear drops irq", int'(irq_rx), 0);
      wr('h08, 'h50);
      chk("R9 irq stays low", int'(irq_rx), 0);
      push('h22);
      chk("R6 irq again", int'(irq_rx), 1);
      wr('h10, 'hfd);
      chk("R9 bit1 zero drops irq", int'(irq_rx), 0);
      rd('h10, v);
      chk("R9 rfull cleared", (v >> 1) & 1, 0);
      wr('h10, 'hff);
      push('h23);
      chk("R6 irq third", int'(irq_rx), 1);
      wr('h10, 'hfe);
      chk("R9 bit0 zero drops irq", int'(irq_rx), 0);
      rd('h10, v);
      chk("R9 rfull kept by writing one", (v >> 1) & 1, 1);

      // R14 simultaneous push and pop
      chk_reg("R14 count before", 'h1c, 3);
      @(negedge clk);
      rx_valid = 1; rx_data = 8'h77;
      bus_sel = 1; bus_we = 0; bus_addr = 6'h14;
      #1 v = int'(bus_rdata);
      @(negedge clk);
      rx_valid = 0; bus_sel = 0;
      chk("R14 popped oldest", v, 'h21);
      chk_reg("R14 count unchanged", 'h1c, 3);
      chk_reg("R14 next byte", 'h14, 'h22);
      chk_reg("R14 next byte", 'h14, 'h23);
      chk_reg("R14 pushed byte", 'h14, 'h77);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule